// File: doc/BRIEF.md
# Oversampled Bit Filter and Bit-Clock Recovery

This block sits right behind a paging receiver's data output. It turns an asynchronous, noisy serial stream into one clean data bit per bit period, with a single-cycle strobe that marks each new bit. An enable pulse, made outside the block, arrives sixteen times per nominal bit period at the selected rate (512, 1200 or 2400 bit/s). The raw line first passes through a synchronizer and an optional polarity flip. The resulting samples are then counted over one bit window, and the bit is decided by majority.

The bit windows come from a 9-bit phase accumulator. It holds 512 counts per bit, which is 16 sample slots of 32 counts each, and a bit closes on the sample event where the phase passes 512. The first level change inside each window is compared with the window's middle, and the next window is then lengthened or shortened by one step. The step is large while a downstream detector reports no lock, and small once it reports that a preamble or sync word has been found.

Top module: `rxbit_recover`

## Requirements
- R1: While reset is high and in the first cycle after it, `bit_out` and `bit_stb` are 0. The phase restarts at 0, so the first bit window holds exactly 16 samples.
- R2: When `invert_cfg` is 1, the synchronized sample is the complement of `rx_raw`, and every later stage sees only this corrected value.
- R3: When a window closes, `bit_out` becomes 1 if more than half of the window's samples are 1, and 0 if fewer than half are 1. `bit_out` changes only in a cycle in which `bit_stb` is high.
- R4: If exactly half of a window's samples are 1, `bit_out` keeps its previous value.
- R5: `bit_stb` is high for exactly one clock cycle per bit. That cycle follows the `samp_en` cycle that closes the window. With no correction pending, a window spans 16 sample events.
- R6: A level change on the first sample of a window is taken as aligned, and no correction follows it.
- R7: Sample k of a window (k = 0 is the first) has post-increment phase o+32(k+1), where o is the phase at the window's start. If the first level change falls on a sample whose post-increment phase is below 256, the next window is lengthened by one step (retard).
- R8: If the first level change falls on a sample whose post-increment phase is 256 or more, the next window is shortened by one step (advance). This includes the sample that closes the window.
- R9: With `locked` at 0, the step is 64 phase counts, i.e. 2 sample slots, so the next window holds 18 or 14 samples.
- R10: With `locked` at 1, the step is 16 phase counts. Starting from phase 0, a retard gives a 17-sample window followed by phase 16. From phase 16, an advance gives a 15-sample window.
- R11: Only the first level change of a window is judged, and at most one step is applied per bit. The step is applied at the sample where the phase of the following window crosses 256.
- R12: A window that has no level change causes no correction, so the window after it holds 16 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | One-cycle sample enable, 16 per nominal bit |
| rx_raw | input | 1 | Asynchronous data from the receiver |
| invert_cfg | input | 1 | 1 = complement the incoming data |
| locked | input | 1 | 1 = downstream logic has seen preamble or sync word (fine step) |
| bit_out | output | 1 | Majority-decided data bit |
| bit_stb | output | 1 | One-cycle strobe marking a new `bit_out` |

## Verification
Two things can happen on the same sample event: the closing of a bit's vote, and the judging of a level change. The bench provokes this by moving the data on the 16th sample of a window. That sample must be counted in the closing vote, and its change must be charged to the closing bit as an early transition, so the next window must hold 14 samples. A second collision is a window split 8 to 8 that also holds a mid-window change. Here the held bit value and the advance that follows it are judged in the same window and in the next window's length.

// File: rtl/rxbit_pkg.sv
package rxbit_pkg;

    typedef enum logic [1:0] {
        NUDGE_NONE    = 2'd0,
        NUDGE_RETARD  = 2'd1,
        NUDGE_ADVANCE = 2'd2
    } nudge_e;

    // Majority decision over one window; an exact half keeps the old bit.
    function automatic logic vote_decide(input int ones, input int total, input logic prev);
        if (2 * ones > total)       return 1'b1;
        else if (2 * ones == total) return prev;
        else                        return 1'b0;
    endfunction

endpackage

// File: rtl/rxbit_sync.sv
module rxbit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_raw,
    input  logic invert_cfg,
    output logic smp
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= rx_raw;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    // Polarity correction ahead of every later stage (R2).
    assign smp = chain[STAGES-1] ^ invert_cfg;

endmodule

// File: rtl/rxbit_vote.sv
module rxbit_vote #(
    parameter int SAMPLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic samp_en,
    input  logic smp,
    input  logic wrap,
    output logic bit_out,
    output logic bit_stb
);
    import rxbit_pkg::*;

    localparam int CNT_W = $clog2(2 * SAMPLES + 1);

    logic [CNT_W-1:0] ones_q, tot_q;
    logic [CNT_W-1:0] ones_n, tot_n;

    always_comb begin
        ones_n = ones_q + CNT_W'(smp);
        tot_n  = tot_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q  <= '0;
            tot_q   <= '0;
            bit_out <= 1'b0;
            bit_stb <= 1'b0;
        end else begin
            bit_stb <= 1'b0;
            if (samp_en) begin
                if (wrap) begin
                    bit_out <= vote_decide(int'(ones_n), int'(tot_n), bit_out);
                    bit_stb <= 1'b1;
                    ones_q  <= '0;
                    tot_q   <= '0;
                end else begin
                    ones_q  <= ones_n;
                    tot_q   <= tot_n;
                end
            end
        end
    end

    assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);

    assert_strobe_cause_R5: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> $past(samp_en));

    assert_out_moves_on_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        (bit_out != $past(bit_out)) |-> bit_stb);

endmodule

// File: rtl/rxbit_phase.sv
module rxbit_phase #(
    parameter int SAMPLES    = 16,
    parameter int SUBSTEPS   = 32,
    parameter int COARSE_DIV = 8,
    parameter int FINE_DIV   = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic samp_en,
    input  logic smp,
    input  logic locked,
    output logic wrap
);
    import rxbit_pkg::*;

    localparam int SPAN   = SAMPLES * SUBSTEPS;
    localparam int PH_W   = $clog2(SPAN);
    localparam int HALF   = SPAN / 2;
    localparam int COARSE = SPAN / COARSE_DIV;
    localparam int FINE   = SPAN / FINE_DIV;

    logic [PH_W-1:0] acc, nxt_acc, step;
    logic [PH_W:0]   sum;
    logic            first_q, prev_q, seen_q;
    logic            edge_det, mid;
    nudge_e          win_q, pend_q, cls, close_dir;

    always_comb begin
        sum      = {1'b0, acc} + (PH_W+1)'(SUBSTEPS);
        wrap     = samp_en && sum[PH_W];
        edge_det = (smp != prev_q);
        // First sample of a window counts as aligned (R6).
        if (first_q)                       cls = NUDGE_NONE;
        else if (sum >= (PH_W+1)'(HALF))   cls = NUDGE_ADVANCE;
        else                               cls = NUDGE_RETARD;
        close_dir = seen_q ? win_q : (edge_det ? cls : NUDGE_NONE);
        // Crossing of the window middle, where a pending step lands.
        mid  = !acc[PH_W-1] && sum[PH_W-1] && !sum[PH_W];
        step = locked ? PH_W'(FINE) : PH_W'(COARSE);
        nxt_acc = sum[PH_W-1:0];
        if (mid && pend_q == NUDGE_RETARD)  nxt_acc = sum[PH_W-1:0] - step;
        if (mid && pend_q == NUDGE_ADVANCE) nxt_acc = sum[PH_W-1:0] + step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            first_q <= 1'b1;
            prev_q  <= 1'b0;
            seen_q  <= 1'b0;
            win_q   <= NUDGE_NONE;
            pend_q  <= NUDGE_NONE;
        end else if (samp_en) begin
            acc     <= nxt_acc;
            prev_q  <= smp;
            first_q <= wrap;
            if (wrap) begin
                seen_q <= 1'b0;
                win_q  <= NUDGE_NONE;
                pend_q <= close_dir;
            end else begin
                if (mid) pend_q <= NUDGE_NONE;
                if (!seen_q && edge_det) begin
                    seen_q <= 1'b1;
                    win_q  <= cls;
                end
            end
        end
    end

    // Checker: count applied steps per window.
    logic [1:0] applied_cnt;
    always_ff @(posedge clk) begin
        if (rst)
            applied_cnt <= '0;
        else if (samp_en && wrap)
            applied_cnt <= '0;
        else if (samp_en && mid && pend_q != NUDGE_NONE && applied_cnt != 2'd3)
            applied_cnt <= applied_cnt + 2'd1;
    end

    assert_single_nudge_R11: assert property (@(posedge clk) disable iff (rst)
        applied_cnt <= 2'd1);

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !samp_en |=> $stable(acc));

    // Step size follows the lock flag (R9 coarse, R10 fine).
    assert_step_size_R9: assert property (@(posedge clk) disable iff (rst)
        samp_en |=>
            (acc == PH_W'($past(acc) + SUBSTEPS)) ||
            (acc == PH_W'($past(acc) + SUBSTEPS + ($past(locked) ? FINE : COARSE))) ||
            (acc == PH_W'($past(acc) + SUBSTEPS - ($past(locked) ? FINE : COARSE))));

endmodule

// File: rtl/rxbit_recover.sv
module rxbit_recover #(
    parameter int SAMPLES     = 16,
    parameter int SUBSTEPS    = 32,
    parameter int COARSE_DIV  = 8,
    parameter int FINE_DIV    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic samp_en,
    input  logic rx_raw,
    input  logic invert_cfg,
    input  logic locked,
    output logic bit_out,
    output logic bit_stb
);
    logic smp;
    logic wrap;

    rxbit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .rx_raw     (rx_raw),
        .invert_cfg (invert_cfg),
        .smp        (smp)
    );

    rxbit_phase #(
        .SAMPLES    (SAMPLES),
        .SUBSTEPS   (SUBSTEPS),
        .COARSE_DIV (COARSE_DIV),
        .FINE_DIV   (FINE_DIV)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .samp_en (samp_en),
        .smp     (smp),
        .locked  (locked),
        .wrap    (wrap)
    );

    rxbit_vote #(.SAMPLES(SAMPLES)) u_vote (
        .clk     (clk),
        .rst     (rst),
        .samp_en (samp_en),
        .smp     (smp),
        .wrap    (wrap),
        .bit_out (bit_out),
        .bit_stb (bit_stb)
    );

endmodule

// File: tb/rxbit_recover_bench.sv
module rxbit_recover_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic samp_en = 1'b0;
    logic rx_raw = 1'b0;
    logic invert_cfg = 1'b0;
    logic locked = 1'b0;
    logic bit_out, bit_stb;

    int checks = 0;
    int fails  = 0;
    logic stray_stb = 1'b0;

    always #10 clk = ~clk;

    rxbit_recover u_rxbit_recover (
        .clk        (clk),
        .rst        (rst),
        .samp_en    (samp_en),
        .rx_raw     (rx_raw),
        .invert_cfg (invert_cfg),
        .locked     (locked),
        .bit_out    (bit_out),
        .bit_stb    (bit_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One sample event: data set, two clocks of synchronizer, one enable cycle.
    task automatic sample(input logic v, output logic stb);
        @(negedge clk); rx_raw = v;
        if (bit_stb) stray_stb = 1'b1;
        @(negedge clk);
        if (bit_stb) stray_stb = 1'b1;
        @(negedge clk); samp_en = 1'b1;
        if (bit_stb) stray_stb = 1'b1;
        @(negedge clk); samp_en = 1'b0;
        stb = bit_stb;
    endtask

    // Feed one window until the strobe; data is pre before chg, post from chg, pre again from back.
    task automatic run_window(input logic pre, input logic post, input int chg, input int back,
                              output int n, output logic b);
        n = 0; b = 1'b0;
        for (int i = 0; i < 40; i++) begin
            logic v, s;
            v = (i < chg) ? pre : ((back >= 0 && i >= back) ? pre : post);
            sample(v, s);
            if (s) begin
                n = i + 1;
                b = bit_out;
                break;
            end
        end
    endtask

    task automatic win(input string req, input logic pre, input logic post, input int chg,
                       input int back, input int exp_n, input logic exp_b);
        int n; logic b;
        run_window(pre, post, chg, back, n, b);
        chk({req, " window length"}, n, exp_n);
        chk({req, " bit value"}, int'(b), int'(exp_b));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 bit_out in reset", int'(bit_out), 0);
        chk("R1 bit_stb in reset", int'(bit_stb), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 bit_out after reset", int'(bit_out), 0);
        chk("R1 bit_stb after reset", int'(bit_stb), 0);
    endtask

    task automatic t_steady;      // R1 R5 R12
        win("R1 first window", 1'b0, 1'b0, 99, -1, 16, 1'b0);
        win("R5 steady zeros", 1'b0, 1'b0, 99, -1, 16, 1'b0);
    endtask

    task automatic t_aligned;     // R6
        win("R6 change on first sample", 1'b0, 1'b1, 0, -1, 16, 1'b1);
        win("R6 no correction after aligned", 1'b1, 1'b1, 99, -1, 16, 1'b1);
    endtask

    task automatic t_coarse_retard;   // R7 R9 R3 R12
        win("R3 late change 5 ones", 1'b1, 1'b0, 5, -1, 16, 1'b0);
        win("R7 R9 retarded window", 1'b0, 1'b0, 99, -1, 18, 1'b0);
        win("R12 no edge no step", 1'b0, 1'b0, 99, -1, 16, 1'b0);
    endtask

    task automatic t_coarse_advance;  // R8 R9
        win("R3 early change 6 ones", 1'b0, 1'b1, 10, -1, 16, 1'b0);
        win("R8 R9 advanced window", 1'b1, 1'b1, 99, -1, 14, 1'b1);
        win("R12 back to nominal", 1'b1, 1'b1, 99, -1, 16, 1'b1);
    endtask

    task automatic t_tie;         // R4
        win("R4 tie keeps one", 1'b1, 1'b0, 8, -1, 16, 1'b1);
        win("R8 after tie", 1'b0, 1'b0, 99, -1, 14, 1'b0);
        win("R12 zeros", 1'b0, 1'b0, 99, -1, 16, 1'b0);
        win("R4 tie keeps zero", 1'b0, 1'b1, 8, -1, 16, 1'b0);
        win("R8 after second tie", 1'b1, 1'b1, 99, -1, 14, 1'b1);
        win("R12 ones", 1'b1, 1'b1, 99, -1, 16, 1'b1);
    endtask

    task automatic t_invert;      // R2
        invert_cfg = 1'b1;
        win("R2 raw zero inverted", 1'b0, 1'b0, 99, -1, 16, 1'b1);
        win("R2 raw one inverted", 1'b1, 1'b1, 99, -1, 16, 1'b0);
    endtask

    task automatic t_fine;        // R10 (raw values, inverted)
        locked = 1'b1;
        win("R10 late change", 1'b1, 1'b0, 5, -1, 16, 1'b1);
        win("R10 fine retard", 1'b0, 1'b0, 99, -1, 17, 1'b1);
        win("R10 early change", 1'b0, 1'b1, 10, -1, 16, 1'b1);
        win("R10 fine advance", 1'b1, 1'b1, 99, -1, 15, 1'b0);
        win("R12 fine idle", 1'b1, 1'b1, 99, -1, 16, 1'b0);
    endtask

    task automatic t_one_step;    // R11
        locked = 1'b0;
        win("R11 pulse window", 1'b1, 1'b0, 5, 10, 16, 1'b0);
        win("R11 only first edge judged", 1'b1, 1'b1, 99, -1, 18, 1'b0);
        win("R12 after single step", 1'b1, 1'b1, 99, -1, 16, 1'b0);
    endtask

    task automatic t_boundary;    // R8 with vote close in the same event
        win("R3 change on closing sample", 1'b1, 1'b0, 15, -1, 16, 1'b0);
        win("R8 closing-sample edge advances", 1'b0, 1'b0, 99, -1, 14, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_steady();
        t_aligned();
        t_coarse_retard();
        t_coarse_advance();
        t_tie();
        t_invert();
        t_fine();
        t_one_step();
        t_boundary();
        chk("R5 strobe only one cycle after sample event", int'(stray_stb), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R5 watchdog expired: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule